// File: doc/BRIEF.md
# E3 Receive Payload Output Interface

This block sits behind an E3 receive framer. Each line-clock cycle it takes one recovered bit and a marker that flags the first bit of a frame. It hands the frame to terminal equipment in one of two ways, picked by a static mode input. In serial mode every bit of the 4296-bit frame leaves on a one-bit output. A flag marks the bits that belong to overhead bytes, and a one-bit-wide pulse marks the first bit of each frame. The exported clock is the line clock, and data changes on its rising edge.

In nibble mode the block keeps only payload bits and packs them into 4-bit words, first-arriving bit in the most significant position. The exported clock is a gapped clock made from registers: two line cycles high and two low for each payload nibble, and no pulse at all while an overhead byte goes by. That gives exactly 1060 pulses per frame. A nibble word changes only while this clock is low, so equipment can sample it on the rising edge. The frame-start output is then held for one nibble period, together with the first payload nibble of the frame.

A frame is 537 bytes, of which 7 are overhead. The overhead byte indices come from a parameter table. The default is bytes 0, 60, 120, 180, 240, 300 and 360. A marker that arrives anywhere other than the expected frame boundary restarts the bit count. The block then treats that bit as the first bit of a new frame.

Top module: `e3_rx_payload_out`

## Requirements
- R1: `nib_mode` low selects serial mode and high selects nibble mode. In nibble mode `ser_data` and `oh_flag` stay 0. In serial mode `nib_data` stays 0.
- R2: In serial mode, a line bit sampled at a rising line-clock edge appears on `ser_data` right after that edge, which is also the rising edge of `out_clk`.
- R3: In nibble mode, `nib_data` changes only while `out_clk` is low, and it is stable across every rising edge of `out_clk`. Each word holds four consecutive payload bits of one byte half, with the earliest bit at bit 3.
- R4: In nibble mode, each payload nibble gives one `out_clk` pulse that is two line cycles high after two line cycles low. An overhead nibble gives no pulse. A full frame therefore gives exactly 1060 pulses.
- R5: In serial mode, `oh_flag` is high exactly in the bit periods in which `ser_data` carries a bit of an overhead byte. It updates on the same edge as `ser_data`.
- R6: In serial mode, `sof` is high for the single bit period in which bit 0 of a frame is on `ser_data`.
- R7: In nibble mode, `sof` is high for one nibble period (four line cycles), together with the first payload nibble of each frame on `nib_data`.
- R8: A frame is 4296 bits, numbered from the marked bit. Byte k covers bits 8k to 8k+7. The bytes listed in the overhead table (by default 0, 60, 120, 180, 240, 300, 360) are overhead, and all other bytes are payload.
- R9: A `frame_mark` that arrives where no frame boundary is expected restarts the count at bit 0. The abandoned frame produces no further nibble pulse, and the start-of-frame indication is issued for the new frame.
- R10: While `rst_n` is low, and after reset until the first `frame_mark`, `ser_data`, `oh_flag`, `sof` and `nib_data` are 0. During that time, in nibble mode, `out_clk` is also 0.
- R11: In serial mode, `out_clk` follows the line clock continuously. It is held low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_mode | input | 1 | Static interface select: 0 serial, 1 nibble |
| line_bit | input | 1 | Recovered line bit |
| frame_mark | input | 1 | High on the first bit of a frame |
| out_clk | output | 1 | Clock exported to terminal equipment |
| ser_data | output | 1 | Serial data, every frame bit |
| oh_flag | output | 1 | High while ser_data carries an overhead bit |
| sof | output | 1 | Start-of-frame indicator |
| nib_data | output | 4 | Payload nibble, first bit at bit 3 |

## Verification
The bench drives random frames in both modes and compares every output against a behavioural model on every cycle. It aims at the last nibble of a frame, whose clock pulse falls in the first cycles of the next frame. A design that dropped or duplicated that pulse would miss the 1060-pulse count. The bench also sends a marker in the middle of a frame. A design that ignored it would place the next frame start and the overhead flags on the old grid. A design that kept the abandoned frame's pending nibble would produce a stray pulse. Overhead bytes directly before payload check that a word change after a gap still happens with the clock low. They also check that no overhead bit leaks into a nibble.

// File: rtl/e3_rx_payload_out.sv
module e3_rx_payload_out #(
  parameter int FRAME_BITS = 4296,
  parameter int OH_COUNT   = 7,
  parameter int BYTE_W     = 10,
  parameter logic [OH_COUNT*BYTE_W-1:0] OH_TABLE = {
    10'd360, 10'd300, 10'd240, 10'd180, 10'd120, 10'd60, 10'd0}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nib_mode,
  input  logic       line_bit,
  input  logic       frame_mark,
  output logic       out_clk,
  output logic       ser_data,
  output logic       oh_flag,
  output logic       sof,
  output logic [3:0] nib_data
);
  localparam int CW = $clog2(FRAME_BITS);

  logic [CW-1:0] cnt_q, pos;
  logic          synced_q, live, at_end, resync, oh_now;
  logic [2:0]    sr_q;
  logic          nclk_q, vld_q, seen_q;
  logic          ser_q, oh_q, sof_q;
  logic [3:0]    nib_q;

  assign at_end = (cnt_q == CW'(FRAME_BITS - 1));
  assign live   = frame_mark | synced_q;
  assign resync = frame_mark & synced_q & ~at_end;
  assign pos    = (frame_mark | at_end) ? '0 : cnt_q + 1'b1;

  always_comb begin
    oh_now = 1'b0;
    for (int i = 0; i < OH_COUNT; i++)
      if (OH_TABLE[i*BYTE_W +: BYTE_W] == BYTE_W'(pos[CW-1:3])) oh_now = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
      sr_q     <= '0;
      nclk_q   <= 1'b0;
      vld_q    <= 1'b0;
      seen_q   <= 1'b0;
      ser_q    <= 1'b0;
      oh_q     <= 1'b0;
      sof_q    <= 1'b0;
      nib_q    <= '0;
    end else if (live) begin
      cnt_q    <= pos;
      synced_q <= 1'b1;
      sr_q     <= {sr_q[1:0], line_bit};
      if (!nib_mode) begin
        ser_q <= line_bit;
        oh_q  <= oh_now;
        sof_q <= (pos == '0);
      end else begin
        if (pos == '0) seen_q <= 1'b0;
        if (resync) vld_q <= 1'b0;
        if (pos[1:0] == 2'd3) begin
          nclk_q <= 1'b0;
          if (!oh_now) begin
            nib_q  <= {sr_q, line_bit};
            vld_q  <= 1'b1;
            sof_q  <= ~seen_q;
            seen_q <= 1'b1;
          end else begin
            vld_q <= 1'b0;
            sof_q <= 1'b0;
          end
        end else begin
          nclk_q <= (pos[1:0] == 2'd1 || pos[1:0] == 2'd2) && vld_q;
        end
      end
    end
  end

  assign out_clk  = rst_n & (nib_mode ? nclk_q : clk);
  assign ser_data = ser_q;
  assign oh_flag  = oh_q;
  assign sof      = sof_q;
  assign nib_data = nib_q;
endmodule

module e3_rx_payload_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nib_mode,
  input logic       out_clk,
  input logic       ser_data,
  input logic       oh_flag,
  input logic       sof,
  input logic [3:0] nib_data
);
  AST_SER_QUIET_IN_NIB: assert property (@(posedge clk) disable iff (!rst_n) nib_mode |-> (!ser_data && !oh_flag)); // R1
  AST_NIB_QUIET_IN_SER: assert property (@(posedge clk) disable iff (!rst_n) !nib_mode |-> (nib_data == 4'd0)); // R1
  AST_NIB_CHANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (nib_mode && !$stable(nib_data)) |-> !out_clk); // R3
  AST_NIB_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (nib_mode && $rose(out_clk)) |-> $stable(nib_data)); // R3
  AST_NCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n) (nib_mode && $rose(out_clk)) |=> out_clk); // R4
  AST_NCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n) (nib_mode && $fell(out_clk)) |=> !out_clk); // R4
  AST_NIB_SOF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (nib_mode && $rose(sof)) |=> sof); // R7
endmodule

bind e3_rx_payload_out e3_rx_payload_out_chk u_chk (.*);

// File: tb/e3_rx_payload_out_tb.sv
`timescale 1ns/1ps
module e3_rx_payload_out_tb;
  localparam int FB = 4296;

  logic clk = 1'b0, rst_n = 1'b0, nib_mode = 1'b0, line_bit = 1'b0, frame_mark = 1'b0;
  logic out_clk, ser_data, oh_flag, sof;
  logic [3:0] nib_data;

  int checks = 0, errors = 0;

  // behavioural model state
  int  m_cnt = 0, m_acc = 0, m_nib = 0;
  bit  m_sync = 0, m_vld = 0, m_seen = 0, m_nclk = 0;
  bit  m_ser = 0, m_oh = 0, m_sof = 0;
  bit  prev_oc = 0;
  int  rises = 0;

  e3_rx_payload_out u_dut (
    .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .line_bit(line_bit),
    .frame_mark(frame_mark), .out_clk(out_clk), .ser_data(ser_data),
    .oh_flag(oh_flag), .sof(sof), .nib_data(nib_data));

  always #10 clk = ~clk;

  function automatic bit byte_is_oh(int b);
    return (b % 60 == 0) && (b <= 360);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int p;
    bit oh, rs;
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_nib = 0; m_sync = 0; m_vld = 0; m_seen = 0;
      m_nclk = 0; m_ser = 0; m_oh = 0; m_sof = 0;
      return;
    end
    if (!frame_mark && !m_sync) return;
    rs = frame_mark && m_sync && (m_cnt != FB - 1);
    p  = (frame_mark || m_cnt == FB - 1) ? 0 : m_cnt + 1;
    m_cnt = p; m_sync = 1;
    oh = byte_is_oh(p / 8);
    m_acc = ((m_acc << 1) | line_bit) & 15;
    if (!nib_mode) begin
      m_ser = line_bit; m_oh = oh; m_sof = (p == 0);
    end else begin
      if (p == 0) m_seen = 0;
      if (rs) m_vld = 0;
      if (p % 4 == 3) begin
        m_nclk = 0;
        if (!oh) begin m_nib = m_acc; m_vld = 1; m_sof = !m_seen; m_seen = 1; end
        else begin m_vld = 0; m_sof = 0; end
      end else m_nclk = ((p % 4 == 1) || (p % 4 == 2)) && m_vld;
    end
  endtask

  task automatic step(bit b, bit m);
    bit exp_oc;
    @(negedge clk);
    line_bit = b; frame_mark = m;
    @(posedge clk);
    #5;
    model_update();
    chk(ser_data == m_ser, "R2", ser_data, m_ser);
    chk(oh_flag == m_oh, nib_mode ? "R1" : "R5 R8", oh_flag, m_oh);
    chk(sof == m_sof, nib_mode ? "R7 R9" : "R6 R9", sof, m_sof);
    chk(nib_data == 4'(m_nib), nib_mode ? "R3 R8" : "R1", nib_data, m_nib);
    exp_oc = !rst_n ? 1'b0 : (nib_mode ? m_nclk : 1'b1);
    chk(out_clk == exp_oc, nib_mode ? "R4" : "R11", out_clk, exp_oc);
    if (nib_mode && out_clk && !prev_oc) rises++;
    prev_oc = out_clk;
  endtask

  task automatic send(int nbits);
    for (int i = 0; i < nbits; i++) step(1'($urandom), i == 0);
  endtask

  initial begin
    // reset state, serial mode
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    chk(!ser_data && !oh_flag && !sof && nib_data == 0 && !out_clk, "R10", out_clk, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    chk(!ser_data && !sof, "R10", ser_data, 0);
    send(FB); send(FB);
    send(1500);
    step(1'b1, 1'b1);
    chk(sof == 1'b1, "R9", sof, 1);
    for (int i = 1; i < FB; i++) step(1'($urandom), 1'b0);
    send(FB);
    // nibble mode
    @(negedge clk); rst_n = 1'b0; nib_mode = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    chk(out_clk == 1'b0 && nib_data == 0, "R10", out_clk, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    chk(out_clk == 1'b0, "R10", out_clk, 0);
    send(FB); send(FB);
    rises = 0;
    send(FB);
    chk(rises == 1060, "R4", rises, 1060);
    send(2001);
    rises = 0;
    send(FB);
    chk(rises == 1059, "R9", rises, 1059);
    rises = 0;
    send(FB);
    chk(rises == 1060, "R4", rises, 1060);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule